// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block collects interrupt requests from four external pins, a set of internal main sources, a set of peripheral sources and a 32-wide DMA request group. It presents them to a CPU through two outputs, a normal request line and a critical request line. Software sets up the block through a small register space of 32-bit words. It then reads one encoded status word to learn which source won in each of three classes: critical, main and peripheral.

Requests pass down a chain. Any unmasked DMA pending bit appears as peripheral code 0. Any unmasked peripheral request appears as main code 4. The winner in each class is the lowest-numbered active request. The status word therefore points software to the next field to read. A main code of 4 means "read the peripheral field", and a peripheral code of 0 means "read the DMA pending word".

Register word addresses on `bus_addr`: 0 control, 1 main mask, 2 peripheral mask, 3 encoded status, 4 DMA pending, 5 DMA mask. Any other address reads as zero. Reads are combinational. A write takes effect at the clock edge where `bus_we` is high.

Top module: `cascade_intc`

## Requirements
- R1: After reset, the control word reads 0, the three mask words read 0xFFFFFFFF, and the DMA pending word and the status word read 0. `irq_o` and `irq_crit_o` are low.
- R2: In every mask word, a 1 disables the matching source. Main code n (5..4+N_MAIN) comes from `main_src[n-5]` and uses main-mask bit 16−n. Peripheral code n (1..N_PER) comes from `per_src[n-1]` and uses peripheral-mask bit 31−n. A masked source is never reported.
- R3: Control bit 12 is a master enable for the external lines. Control bit 11 enables pin 0, and bits 10, 9 and 8 enable pins 1, 2 and 3. An active pin 0 is critical code 0. Active pins 1..3 are main codes 1..3.
- R4: Pin n takes its sense mode from control bits (23−2n):(22−2n): 0 level-high, 3 level-low, 1 rising edge latched, 2 falling edge latched. The edge latch of pin n reads back at control bit 27−n. Writing 1 to that bit clears the latch, and writing 0 leaves it unchanged.
- R5: A high level on `crit_src` latches critical code 3. Writing 1 to status bit 10 clears that latch. When both critical codes are active, code 0 is reported.
- R6: The status word has these fields: bit 10 critical valid with code in 9:8, bit 21 main valid with code in 20:16, and bit 29 peripheral valid with code in 28:24. All other bits are 0. Each field holds the lowest active code, and a field reads 0 when its valid bit is clear.
- R7: When any peripheral code is reported and main-mask bit 12 is 0, main code 4 is active.
- R8: A high `dma_src[n]` sets DMA pending bit n, which then stays set until software writes 1 to that bit. Setting a DMA mask bit to 1 disables that source. Any pending bit whose mask bit is 0 makes peripheral code 0 active, and this code is gated by peripheral-mask bit 31.
- R9: `irq_crit_o` is high when a critical code is valid and control bit 0 is 1. `irq_o` is high when a main or peripheral code is valid, and also when a critical code is valid while control bit 0 is 0.
- R10: When a source sets a latched bit in the same cycle that software clears it (edge latch, critical latch or DMA pending), the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ext_irq | input | 4 | External interrupt pins 0..3 |
| crit_src | input | 1 | Internal critical request |
| main_src | input | N_MAIN | Internal main requests, level |
| per_src | input | N_PER | Peripheral requests, level |
| dma_src | input | N_DMA | DMA request group, sets pending bits |
| irq_o | output | 1 | Normal interrupt to the CPU |
| irq_crit_o | output | 1 | Critical interrupt to the CPU |

## Verification
On every cycle, the assertions check that each reported main code is the lowest active request, that a reported peripheral code has its mask bit clear, and that the two outputs agree with the valid flags and the routing bit. They also check that clear-without-set empties the edge latch, the critical latch and the DMA pending word, and that a set always wins. The exact bit layout of the status word and the mapping from source number to mask bit are checked only by the bench. The same holds for the four sense modes and for the chain from DMA group through peripheral code 0 to main code 4. Each of these is driven by a directed scenario and read back through the register port.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_MMASK = 3'd1;
   localparam logic [2:0] A_PMASK = 3'd2;
   localparam logic [2:0] A_STAT  = 3'd3;
   localparam logic [2:0] A_DPEND = 3'd4;
   localparam logic [2:0] A_DMASK = 3'd5;
   localparam int MASTER_BIT  = 12;
   localparam int ROUTE_BIT   = 0;
   localparam int CRIT_ACK    = 10;
   localparam int CASCADE_BIT = 12;
   localparam logic [31:0] CTRL_STORE = 32'h00FF_1F01;
   typedef enum logic [1:0] {
      SENSE_HIGH = 2'd0, SENSE_RISE = 2'd1, SENSE_FALL = 2'd2, SENSE_LOW = 2'd3
   } sense_e;
endpackage

// File: rtl/cic_ext_line.sv
module cic_ext_line
   import cic_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] mode,
   input  logic       clr,
   output logic       req,
   output logic       latched
);
   logic prev_q, lat_q, set;
   sense_e m;

   assign m = sense_e'(mode);

   always_comb begin
      case (m)
         SENSE_RISE: set = pin & ~prev_q;
         SENSE_FALL: set = ~pin & prev_q;
         default:    set = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= pin;
         lat_q  <= (lat_q & ~clr) | set;
      end
   end

   always_comb begin
      case (m)
         SENSE_HIGH: req = pin;
         SENSE_LOW:  req = ~pin;
         default:    req = lat_q;
      endcase
   end
   assign latched = lat_q;

   a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !lat_q);
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> lat_q);
endmodule

// File: rtl/cic_lowest.sv
module cic_lowest #(
   parameter int W  = 4,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req,
   output logic          valid,
   output logic [IW-1:0] idx
);
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            valid = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
   import cic_pkg::*;
#(
   parameter int N_MAIN = 12,
   parameter int N_PER  = 23,
   parameter int N_DMA  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [3:0]        ext_irq,
   input  logic              crit_src,
   input  logic [N_MAIN-1:0] main_src,
   input  logic [N_PER-1:0]  per_src,
   input  logic [N_DMA-1:0]  dma_src,
   output logic              irq_o,
   output logic              irq_crit_o
);
   localparam int MAIN_CODES = 5 + N_MAIN;
   localparam int PER_CODES  = 1 + N_PER;
   localparam int MIW = $clog2(MAIN_CODES);
   localparam int PIW = $clog2(PER_CODES);

   generate
      if (N_MAIN < 1 || N_MAIN > 12) begin : g_bad_main
         $error("N_MAIN must be 1..12");
      end
      if (N_PER < 1 || N_PER > 31) begin : g_bad_per
         $error("N_PER must be 1..31");
      end
      if (N_DMA < 1 || N_DMA > 32) begin : g_bad_dma
         $error("N_DMA must be 1..32");
      end
   endgenerate

   logic [31:0] ctrl_q, mmask_q, pmask_q, dpend_q, dmask_q;
   logic        crit_pend_q;
   logic        wr_ctrl, wr_stat, wr_dpend;
   logic [31:0] dma_set;

   assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
   assign wr_stat  = bus_we && (bus_addr == A_STAT);
   assign wr_dpend = bus_we && (bus_addr == A_DPEND);
   assign dma_set  = 32'(dma_src);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         mmask_q     <= '1;
         pmask_q     <= '1;
         dmask_q     <= '1;
         dpend_q     <= '0;
         crit_pend_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_STORE;
         if (bus_we && bus_addr == A_MMASK) mmask_q <= bus_wdata;
         if (bus_we && bus_addr == A_PMASK) pmask_q <= bus_wdata;
         if (bus_we && bus_addr == A_DMASK) dmask_q <= bus_wdata;
         dpend_q     <= (dpend_q & ~(wr_dpend ? bus_wdata : 32'h0)) | dma_set;
         crit_pend_q <= (crit_pend_q & ~(wr_stat && bus_wdata[CRIT_ACK])) | crit_src;
      end
   end

   // external pins
   logic [3:0] line_req, line_lat, ext_act;
   for (genvar n = 0; n < 4; n++) begin : g_line
      cic_ext_line u_line (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (ext_irq[n]),
         .mode    (ctrl_q[23-2*n -: 2]),
         .clr     (wr_ctrl && bus_wdata[27-n]),
         .req     (line_req[n]),
         .latched (line_lat[n])
      );
      assign ext_act[n] = line_req[n] & ctrl_q[11-n] & ctrl_q[MASTER_BIT];
   end

   // critical class
   logic [3:0] crit_req;
   logic       crit_v;
   logic [1:0] crit_idx;
   assign crit_req = {crit_pend_q, 2'b00, ext_act[0]};
   cic_lowest #(.W(4)) u_crit (.req(crit_req), .valid(crit_v), .idx(crit_idx));

   // peripheral class, code 0 is the DMA group
   logic [PER_CODES-1:0] per_req;
   logic                 per_v;
   logic [PIW-1:0]       per_idx;
   assign per_req[0] = (|(dpend_q & ~dmask_q)) & ~pmask_q[31];
   for (genvar n = 1; n < PER_CODES; n++) begin : g_per
      assign per_req[n] = per_src[n-1] & ~pmask_q[31-n];
   end
   cic_lowest #(.W(PER_CODES)) u_per (.req(per_req), .valid(per_v), .idx(per_idx));

   // main class, code 4 is the peripheral cascade
   logic [MAIN_CODES-1:0] main_req;
   logic                  main_v;
   logic [MIW-1:0]        main_idx;
   assign main_req[0]   = 1'b0;
   assign main_req[3:1] = ext_act[3:1];
   assign main_req[4]   = per_v & ~mmask_q[CASCADE_BIT];
   for (genvar n = 5; n < MAIN_CODES; n++) begin : g_main
      assign main_req[n] = main_src[n-5] & ~mmask_q[16-n];
   end
   cic_lowest #(.W(MAIN_CODES)) u_main (.req(main_req), .valid(main_v), .idx(main_idx));

   logic [31:0] status;
   always_comb begin
      status        = '0;
      status[10]    = crit_v;
      status[9:8]   = crit_idx;
      status[21]    = main_v;
      status[20:16] = 5'(main_idx);
      status[29]    = per_v;
      status[28:24] = 5'(per_idx);
   end

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = ctrl_q | {4'b0, line_lat[0], line_lat[1], line_lat[2], line_lat[3], 24'b0};
         A_MMASK: bus_rdata = mmask_q;
         A_PMASK: bus_rdata = pmask_q;
         A_STAT:  bus_rdata = status;
         A_DPEND: bus_rdata = dpend_q;
         A_DMASK: bus_rdata = dmask_q;
         default: bus_rdata = '0;
      endcase
   end

   assign irq_crit_o = crit_v & ctrl_q[ROUTE_BIT];
   assign irq_o      = main_v | per_v | (crit_v & ~ctrl_q[ROUTE_BIT]);

   a_r2_reported_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      per_v |-> !pmask_q[31 - int'(per_idx)]);
   a_r6_main_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      main_v |-> (main_req[main_idx] &&
                  ((main_req & ~({MAIN_CODES{1'b1}} << main_idx)) == '0)));
   a_r9_crit_route: assert property (@(posedge clk) disable iff (!rst_n)
      irq_crit_o |-> (crit_v && ctrl_q[ROUTE_BIT] && !(irq_o && !main_v && !per_v)));
   a_r9_normal_out: assert property (@(posedge clk) disable iff (!rst_n)
      (main_v || per_v) |-> irq_o);
   a_r8_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dpend && bus_wdata == 32'hFFFF_FFFF && dma_src == '0) |=> (dpend_q == '0));
   a_r5_crit_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[CRIT_ACK] && !crit_src) |=> !crit_pend_q);
   a_r10_crit_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      crit_src |=> crit_pend_q);
endmodule

// File: tb/cascade_intc_bench.sv
`timescale 1ns/1ps
module cascade_intc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  ext_irq = '0;
   logic        crit_src = 1'b0;
   logic [11:0] main_src = '0;
   logic [22:0] per_src = '0;
   logic [31:0] dma_src = '0;
   logic        irq_o, irq_crit_o;
   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cascade_intc u_cascade_intc (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_irq(ext_irq),
      .crit_src(crit_src), .main_src(main_src), .per_src(per_src),
      .dma_src(dma_src), .irq_o(irq_o), .irq_crit_o(irq_crit_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic t_reset;
      rd("R1 ctrl", 3'd0, 32'h0);
      rd("R1 main mask", 3'd1, 32'hFFFF_FFFF);
      rd("R1 per mask", 3'd2, 32'hFFFF_FFFF);
      rd("R1 status", 3'd3, 32'h0);
      rd("R1 dma pend", 3'd4, 32'h0);
      rd("R1 dma mask", 3'd5, 32'hFFFF_FFFF);
      check("R1 irq_o", 32'(irq_o), 32'h0);
      check("R1 irq_crit_o", 32'(irq_crit_o), 32'h0);
   endtask

   task automatic t_main;
      main_src = 12'b0000_0000_0100;           // code 7, mask bit 9 still set
      rd("R2 masked main quiet", 3'd3, 32'h0);
      check("R2 masked irq_o", 32'(irq_o), 32'h0);
      main_src = 12'b0000_0000_1001;           // codes 5 and 8
      wr(3'd1, ~((32'h1 << 11) | (32'h1 << 8)));
      rd("R6 main lowest code 5", 3'd3, 32'h0025_0000);
      check("R9 irq_o from main", 32'(irq_o), 32'h1);
      wr(3'd1, ~(32'h1 << 8));
      rd("R2 main code 8 after mask", 3'd3, 32'h0028_0000);
      main_src = '0;
      wr(3'd1, 32'hFFFF_FFFF);
   endtask

   task automatic t_per;
      per_src = 23'h10;                        // code 5, mask bit 26
      wr(3'd2, ~(32'h1 << 26));
      rd("R2 per code 5", 3'd3, 32'h2500_0000);
      check("R9 irq_o from per", 32'(irq_o), 32'h1);
      wr(3'd1, ~(32'h1 << 12));
      rd("R7 cascade main code 4", 3'd3, 32'h2524_0000);
      per_src = '0;
      #1;
      rd("R7 cascade drops", 3'd3, 32'h0);
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_ext;
      wr(3'd0, 32'h0000_1400);                 // master + pin1, level high
      ext_irq = 4'b0010;
      rd("R3 pin1 main code 1", 3'd3, 32'h0021_0000);
      ext_irq = 4'b0000;
      rd("R4 level high idle", 3'd3, 32'h0);
      wr(3'd0, 32'h0030_1400);                 // level low
      rd("R4 level low active", 3'd3, 32'h0021_0000);
      wr(3'd0, 32'h0030_0400);                 // master off
      rd("R3 master off", 3'd3, 32'h0);
      wr(3'd0, 32'h0004_1200);                 // pin2 rising
      @(negedge clk); ext_irq = 4'b0100;
      @(negedge clk); ext_irq = 4'b0000;
      @(negedge clk);
      rd("R4 edge latch readback", 3'd0, 32'h0204_1200);
      rd("R3 pin2 main code 2", 3'd3, 32'h0022_0000);
      wr(3'd0, 32'h0004_1200);
      rd("R4 write 0 keeps latch", 3'd0, 32'h0204_1200);
      wr(3'd0, 32'h0204_1200);
      rd("R4 write 1 clears latch", 3'd0, 32'h0004_1200);
      rd("R4 status idle", 3'd3, 32'h0);
      wr(3'd0, 32'h0);
   endtask

   task automatic t_crit;
      wr(3'd0, 32'h0000_0001);
      @(negedge clk); crit_src = 1'b1;
      @(negedge clk); crit_src = 1'b0;
      rd("R5 crit code 3", 3'd3, 32'h0000_0700);
      check("R9 crit out", 32'(irq_crit_o), 32'h1);
      check("R9 normal quiet", 32'(irq_o), 32'h0);
      wr(3'd0, 32'h0);
      check("R9 routed normal", 32'(irq_o), 32'h1);
      check("R9 crit out low", 32'(irq_crit_o), 32'h0);
      wr(3'd0, 32'h0000_1801);
      ext_irq = 4'b0001;
      rd("R5 pin0 beats code 3", 3'd3, 32'h0000_0400);
      ext_irq = 4'b0000;
      crit_src = 1'b1;
      wr(3'd3, 32'h0000_0400);
      rd("R10 crit set wins", 3'd3, 32'h0000_0700);
      crit_src = 1'b0;
      wr(3'd3, 32'h0000_0400);
      rd("R5 ack clears", 3'd3, 32'h0);
      check("R5 crit out low", 32'(irq_crit_o), 32'h0);
      wr(3'd0, 32'h0);
   endtask

   task automatic t_dma;
      @(negedge clk); dma_src = 32'h20;
      @(negedge clk); dma_src = 32'h08;
      @(negedge clk); dma_src = 32'h0;
      rd("R8 pending sticky", 3'd4, 32'h28);
      rd("R8 masked dma quiet", 3'd3, 32'h0);
      wr(3'd5, ~32'h20);
      wr(3'd2, ~(32'h1 << 31));
      rd("R8 per code 0", 3'd3, 32'h2000_0000);
      wr(3'd4, 32'h0);
      rd("R8 write 0 no effect", 3'd4, 32'h28);
      wr(3'd4, 32'h8);
      rd("R8 write 1 clears", 3'd4, 32'h20);
      dma_src = 32'h20;
      wr(3'd4, 32'h20);
      dma_src = 32'h0;
      rd("R10 dma set wins", 3'd4, 32'h20);
      wr(3'd4, 32'h20);
      rd("R8 pending empty", 3'd4, 32'h0);
      rd("R8 per code gone", 3'd3, 32'h0);
      wr(3'd2, 32'hFFFF_FFFF);
      wr(3'd5, 32'hFFFF_FFFF);
   endtask

   initial begin
      #100000;
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_main;
      t_per;
      t_ext;
      t_crit;
      t_dma;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule